// File: doc/BRIEF.md
# Late-Write Buffer with Read Bypass

This block sits between a command front end and a synchronous memory array that holds word pairs. A write command gives its address in one cycle, and its data follows on a separate bus in the next cycle. The block does not write the array in that cycle. It parks each completed write in a small two-deep holding queue and pushes the oldest entry into the array only when a newer write's data arrives. The array is therefore written on the third write cycle of a write stream.

Every read address goes to the array and is also compared in the same cycle against three sources: the write whose data is on the bus now, the younger queue entry and the older queue entry. Each lane of the pair is served from the youngest matching source that holds valid data for that lane. Lanes with no match come from the array. This lets a read follow a write directly, with no idle or flush cycle between them.

A double-rate write fills both lanes. A single-rate write fills one lane, chosen by a lane select, and only that lane is forwarded or committed.

Top module: `late_write_buffer`

## Requirements
- R1: While reset is held low, and in the first cycle after reset with idle inputs, `rd_valid`, `arr_rd_en` and `arr_wr_en` are 0. Reset discards all queued writes, so none of them is ever forwarded or committed afterwards.
- R2: A write command's data is taken from `wr_data` in the cycle after the command. No data is sampled in the command's own cycle.
- R3: A read command in cycle n drives `arr_rd_en` with `arr_rd_addr` = `cmd_addr` in cycle n. The block then raises `rd_valid` with the result in cycle n+1. `rd_valid` is low in any cycle that does not follow a read command.
- R4: The array is written only in a cycle in which write data arrives while both queue stages are occupied. The entry committed is the oldest one, so a write reaches the array when the second write after it delivers its data.
- R5: A sequence of reads and idle cycles never writes the array. Queued entries stay queued and keep being forwarded.
- R6: A read returns the newest written value of its address. This includes a write whose data arrives in the same cycle as the read command, and entries still in either queue stage.
- R7: When several sources match a read address for the same lane, the priority is: incoming data first, then the younger stage, then the older stage.
- R8: When `cmd_ddr`=0, a write fills only the lane selected by `cmd_lane`. Lane 0 is `wr_data[15:0]` and lane 1 is `wr_data[31:16]`. A read of that address takes the other lane from the array or from an older matching entry.
- R9: `rd_lanes` is 2'b11 for a double-rate read. For a single-rate read it is 2'b01 when `cmd_lane`=0 and 2'b10 when `cmd_lane`=1. `rd_data` always carries both lanes.
- R10: A commit drives `arr_wr_mask` with bit 0 for lane 0 and bit 1 for lane 1, set exactly for the lanes that the committed write filled. `arr_wr_data` carries that write's data in those lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_ddr | input | 1 | 1 = both lanes, 0 = one lane |
| cmd_lane | input | 1 | Lane used when cmd_ddr is 0 |
| cmd_addr | input | ADDR_W | Word-pair address |
| wr_data | input | 2*LANE_W | Write data, one cycle after its command |
| arr_rd_en | output | 1 | Array read strobe |
| arr_rd_addr | output | ADDR_W | Array read address |
| arr_rd_data | input | 2*LANE_W | Array read data, one cycle after the strobe |
| arr_wr_en | output | 1 | Array write strobe (commit) |
| arr_wr_addr | output | ADDR_W | Commit address |
| arr_wr_mask | output | 2 | Per-lane commit enables |
| arr_wr_data | output | 2*LANE_W | Commit data |
| rd_valid | output | 1 | Read result valid |
| rd_lanes | output | 2 | Lanes requested by the read |
| rd_data | output | 2*LANE_W | Coherent read data, both lanes |

## Verification
The bench drives inputs at the falling edge. It sets the expected value of a read from its own coherent memory model at the moment the read command is driven. The model is updated first with any write data that sits on the bus in that same cycle. That expected value is compared against `rd_data` and `rd_lanes` one cycle later, because the registered bypass and the array's one-cycle read latency both land there. Commit strobes depend only on registers, so a monitor counts them in the cycle after the third write's command. The directed tests check the count and the committed address, mask and data one cycle after that.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

    localparam int unsigned LANES = 2;

    typedef logic [LANES-1:0] lane_mask_t;

    // Lanes touched by a command: both for double rate, one otherwise.
    function automatic lane_mask_t lane_select(input logic ddr, input logic lane);
        lane_mask_t m;
        if (ddr) begin
            m = '1;
        end else begin
            m = '0;
            m[lane] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/lwb_capture.sv
// Holds a write command's address and lanes for one cycle, so the entry can
// be completed when the data beat arrives.
module lwb_capture
    import lwb_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_cmd_i,
    input  logic                  ddr_i,
    input  logic                  lane_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [LANES*DW-1:0]   wr_data_i,
    output logic                  new_vld_o,
    output logic [AW-1:0]         new_addr_o,
    output lane_mask_t            new_mask_o,
    output logic [LANES*DW-1:0]   new_data_o
);

    typedef struct packed {
        logic        vld;
        logic [AW-1:0] addr;
        lane_mask_t  mask;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d      = hold_q;
        hold_d.vld  = wr_cmd_i;
        if (wr_cmd_i) begin
            hold_d.addr = addr_i;
            hold_d.mask = lane_select(ddr_i, lane_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign new_vld_o  = hold_q.vld;
    assign new_addr_o = hold_q.addr;
    assign new_mask_o = hold_q.mask;
    assign new_data_o = wr_data_i;

endmodule

// File: rtl/lwb_stages.sv
// Shift queue of completed writes; the oldest entry leaves toward the array
// when a new one is pushed while the queue is full.
module lwb_stages
    import lwb_pkg::*;
#(
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               push_i,
    input  logic [AW-1:0]                      in_addr_i,
    input  lane_mask_t                         in_mask_i,
    input  logic [LANES*DW-1:0]                in_data_i,
    output logic [DEPTH-1:0]                   stg_vld_o,
    output logic [DEPTH-1:0][AW-1:0]           stg_addr_o,
    output logic [DEPTH-1:0][LANES-1:0]        stg_mask_o,
    output logic [DEPTH-1:0][LANES*DW-1:0]     stg_data_o,
    output logic                               commit_en_o,
    output logic [AW-1:0]                      commit_addr_o,
    output lane_mask_t                         commit_mask_o,
    output logic [LANES*DW-1:0]                commit_data_o
);

    localparam int unsigned OLDEST = DEPTH - 1;

    typedef struct packed {
        logic                vld;
        logic [AW-1:0]       addr;
        lane_mask_t          mask;
        logic [LANES*DW-1:0] data;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] e;
    } queue_t;

    queue_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (push_i) begin
            for (int i = DEPTH - 1; i > 0; i--) begin
                q_d.e[i] = q_q.e[i-1];
            end
            q_d.e[0].vld  = 1'b1;
            q_d.e[0].addr = in_addr_i;
            q_d.e[0].mask = in_mask_i;
            q_d.e[0].data = in_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_out
        assign stg_vld_o[s]  = q_q.e[s].vld;
        assign stg_addr_o[s] = q_q.e[s].addr;
        assign stg_mask_o[s] = q_q.e[s].mask;
        assign stg_data_o[s] = q_q.e[s].data;
    end

    assign commit_en_o   = push_i && q_q.e[OLDEST].vld;
    assign commit_addr_o = q_q.e[OLDEST].addr;
    assign commit_mask_o = q_q.e[OLDEST].mask;
    assign commit_data_o = q_q.e[OLDEST].data;

endmodule

// File: rtl/lwb_forward.sv
// Per-lane address compare over N candidates; index 0 is the youngest and
// wins over every higher index.
module lwb_forward
    import lwb_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 16,
    parameter int unsigned N  = 3
) (
    input  logic [AW-1:0]                  rd_addr_i,
    input  logic [N-1:0]                   cand_vld_i,
    input  logic [N-1:0][AW-1:0]           cand_addr_i,
    input  logic [N-1:0][LANES-1:0]        cand_mask_i,
    input  logic [N-1:0][LANES*DW-1:0]     cand_data_i,
    output lane_mask_t                     hit_o,
    output logic [LANES*DW-1:0]            data_o
);

    logic [N-1:0] addr_eq;

    for (genvar c = 0; c < N; c++) begin : g_cmp
        assign addr_eq[c] = cand_vld_i[c] && (cand_addr_i[c] == rd_addr_i);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic          lane_hit;
        logic [DW-1:0] lane_data;

        always_comb begin
            lane_hit  = 1'b0;
            lane_data = '0;
            for (int i = N - 1; i >= 0; i--) begin
                if (addr_eq[i] && cand_mask_i[i][l]) begin
                    lane_hit  = 1'b1;
                    lane_data = cand_data_i[i][l*DW +: DW];
                end
            end
        end

        assign hit_o[l]              = lane_hit;
        assign data_o[l*DW +: DW]    = lane_data;
    end

endmodule

// File: rtl/late_write_buffer.sv
module late_write_buffer
    import lwb_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANE_W = 16,
    parameter int unsigned DEPTH  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic                    cmd_write,
    input  logic                    cmd_ddr,
    input  logic                    cmd_lane,
    input  logic [ADDR_W-1:0]       cmd_addr,
    input  logic [2*LANE_W-1:0]     wr_data,
    output logic                    arr_rd_en,
    output logic [ADDR_W-1:0]       arr_rd_addr,
    input  logic [2*LANE_W-1:0]     arr_rd_data,
    output logic                    arr_wr_en,
    output logic [ADDR_W-1:0]       arr_wr_addr,
    output logic [1:0]              arr_wr_mask,
    output logic [2*LANE_W-1:0]     arr_wr_data,
    output logic                    rd_valid,
    output logic [1:0]              rd_lanes,
    output logic [2*LANE_W-1:0]     rd_data
);

    localparam int unsigned PAIR_W = LANES * LANE_W;
    localparam int unsigned NCAND  = DEPTH + 1;

    // Incoming write (data beat on the bus this cycle)
    logic                 new_vld;
    logic [ADDR_W-1:0]    new_addr;
    lane_mask_t           new_mask;
    logic [PAIR_W-1:0]    new_data;

    lwb_capture #(.AW(ADDR_W), .DW(LANE_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cmd_i   (cmd_valid && cmd_write),
        .ddr_i      (cmd_ddr),
        .lane_i     (cmd_lane),
        .addr_i     (cmd_addr),
        .wr_data_i  (wr_data),
        .new_vld_o  (new_vld),
        .new_addr_o (new_addr),
        .new_mask_o (new_mask),
        .new_data_o (new_data)
    );

    // Queued writes
    logic [DEPTH-1:0]                 stg_vld;
    logic [DEPTH-1:0][ADDR_W-1:0]     stg_addr;
    logic [DEPTH-1:0][LANES-1:0]      stg_mask;
    logic [DEPTH-1:0][PAIR_W-1:0]     stg_data;
    lane_mask_t                       commit_mask;

    lwb_stages #(.AW(ADDR_W), .DW(LANE_W), .DEPTH(DEPTH)) u_stages (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_i        (new_vld),
        .in_addr_i     (new_addr),
        .in_mask_i     (new_mask),
        .in_data_i     (new_data),
        .stg_vld_o     (stg_vld),
        .stg_addr_o    (stg_addr),
        .stg_mask_o    (stg_mask),
        .stg_data_o    (stg_data),
        .commit_en_o   (arr_wr_en),
        .commit_addr_o (arr_wr_addr),
        .commit_mask_o (commit_mask),
        .commit_data_o (arr_wr_data)
    );

    assign arr_wr_mask = commit_mask;

    // Candidate list, youngest first
    logic [NCAND-1:0]                 cand_vld;
    logic [NCAND-1:0][ADDR_W-1:0]     cand_addr;
    logic [NCAND-1:0][LANES-1:0]      cand_mask;
    logic [NCAND-1:0][PAIR_W-1:0]     cand_data;

    assign cand_vld[0]  = new_vld;
    assign cand_addr[0] = new_addr;
    assign cand_mask[0] = new_mask;
    assign cand_data[0] = new_data;

    for (genvar s = 0; s < DEPTH; s++) begin : g_cand
        assign cand_vld[s+1]  = stg_vld[s];
        assign cand_addr[s+1] = stg_addr[s];
        assign cand_mask[s+1] = stg_mask[s];
        assign cand_data[s+1] = stg_data[s];
    end

    lane_mask_t          fwd_hit;
    logic [PAIR_W-1:0]   fwd_data;

    lwb_forward #(.AW(ADDR_W), .DW(LANE_W), .N(NCAND)) u_forward (
        .rd_addr_i   (cmd_addr),
        .cand_vld_i  (cand_vld),
        .cand_addr_i (cand_addr),
        .cand_mask_i (cand_mask),
        .cand_data_i (cand_data),
        .hit_o       (fwd_hit),
        .data_o      (fwd_data)
    );

    // Read return register, aligned with the array's one-cycle latency
    typedef struct packed {
        logic              vld;
        lane_mask_t        lanes;
        lane_mask_t        hit;
        logic [PAIR_W-1:0] fwd;
    } rd_state_t;

    rd_state_t rd_d, rd_q;
    logic      rd_cmd;

    assign rd_cmd      = cmd_valid && !cmd_write;
    assign arr_rd_en   = rd_cmd;
    assign arr_rd_addr = cmd_addr;

    always_comb begin
        rd_d     = rd_q;
        rd_d.vld = rd_cmd;
        if (rd_cmd) begin
            rd_d.lanes = lane_select(cmd_ddr, cmd_lane);
            rd_d.hit   = fwd_hit;
            rd_d.fwd   = fwd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_rd
        assign rd_data[l*LANE_W +: LANE_W] = rd_q.hit[l] ? rd_q.fwd[l*LANE_W +: LANE_W]
                                                         : arr_rd_data[l*LANE_W +: LANE_W];
    end

    assign rd_valid = rd_q.vld;
    assign rd_lanes = rd_q.lanes;

endmodule

// File: rtl/lwb_checker.sv
module lwb_checker #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_write,
    input logic              cmd_ddr,
    input logic              arr_wr_en,
    input logic [1:0]        arr_wr_mask,
    input logic              rd_valid,
    input logic [1:0]        rd_lanes,
    input logic [ADDR_W-1:0] cmd_addr
);

    logic unused_ok;
    assign unused_ok = ^cmd_addr;

    a_r3_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_write) |=> rd_valid);

    a_r3_no_stray_return: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && !cmd_write) |=> !rd_valid);

    a_r4_commit_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> $past(cmd_valid && cmd_write));

    a_r10_commit_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> (arr_wr_mask != 2'b00));

    a_r9_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_write && !cmd_ddr) |=> ($countones(rd_lanes) == 1));

    a_r9_both_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_write && cmd_ddr) |=> (rd_lanes == 2'b11));

endmodule

bind late_write_buffer lwb_checker #(.ADDR_W(ADDR_W)) u_lwb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_write   (cmd_write),
    .cmd_ddr     (cmd_ddr),
    .arr_wr_en   (arr_wr_en),
    .arr_wr_mask (arr_wr_mask),
    .rd_valid    (rd_valid),
    .rd_lanes    (rd_lanes),
    .cmd_addr    (cmd_addr)
);

// File: tb/test_late_write_buffer.sv
module test_late_write_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_ddr = 1'b0, cmd_lane = 1'b0;
    logic [7:0]  cmd_addr = '0;
    logic [31:0] wr_data = '0;
    logic        arr_rd_en, arr_wr_en, rd_valid;
    logic [7:0]  arr_rd_addr, arr_wr_addr;
    logic [31:0] arr_rd_data, arr_wr_data, rd_data;
    logic [1:0]  arr_wr_mask, rd_lanes;

    always #2.5 clk = ~clk;

    late_write_buffer i_late_write_buffer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_ddr(cmd_ddr), .cmd_lane(cmd_lane), .cmd_addr(cmd_addr), .wr_data(wr_data),
        .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data),
        .arr_wr_en(arr_wr_en), .arr_wr_addr(arr_wr_addr), .arr_wr_mask(arr_wr_mask),
        .arr_wr_data(arr_wr_data), .rd_valid(rd_valid), .rd_lanes(rd_lanes), .rd_data(rd_data)
    );

    function automatic logic [31:0] init_word(input logic [7:0] a);
        return {a, ~a, a ^ 8'h5A, 8'hC3};
    endfunction

    // Synchronous array model, one-cycle read, read-first
    logic [31:0] mem_arr [256];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem_arr[i] <= init_word(i[7:0]);
            arr_rd_data <= '0;
        end else begin
            if (arr_rd_en) arr_rd_data <= mem_arr[arr_rd_addr];
            if (arr_wr_en) begin
                if (arr_wr_mask[0]) mem_arr[arr_wr_addr][15:0]  <= arr_wr_data[15:0];
                if (arr_wr_mask[1]) mem_arr[arr_wr_addr][31:16] <= arr_wr_data[31:16];
            end
        end
    end

    // Commit monitor (arr_wr_en depends only on registers)
    int          n_commit = 0;
    logic [7:0]  last_addr = '0;
    logic [1:0]  last_mask = '0;
    logic [31:0] last_data = '0;
    always @(negedge clk) begin
        if (rst_n && arr_wr_en) begin
            n_commit  <= n_commit + 1;
            last_addr <= arr_wr_addr;
            last_mask <= arr_wr_mask;
            last_data <= arr_wr_data;
        end
    end

    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: coherent memory, updated when write data is on the bus
    logic [31:0] ref_mem [256];
    logic        pend_w = 1'b0;
    logic [7:0]  pend_a = '0;
    logic [1:0]  pend_m = '0;
    logic [31:0] pend_d = '0;
    logic        exp_vld = 1'b0;
    logic [31:0] exp_data = '0;
    logic [1:0]  exp_lanes = '0;
    string       exp_req = "";

    task automatic cycle(input logic v, input logic w, input logic ddr, input logic lane,
                         input logic [7:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        if (exp_vld) begin
            chk({exp_req, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
            chk({exp_req, " rd_data"}, rd_data, exp_data);
            chk("R9 rd_lanes", {30'd0, rd_lanes}, {30'd0, exp_lanes});
        end
        wr_data = pend_w ? pend_d : 32'h0;
        if (pend_w) begin
            if (pend_m[0]) ref_mem[pend_a][15:0]  = pend_d[15:0];
            if (pend_m[1]) ref_mem[pend_a][31:16] = pend_d[31:16];
        end
        cmd_valid = v; cmd_write = w; cmd_ddr = ddr; cmd_lane = lane; cmd_addr = a;
        exp_vld   = v && !w;
        exp_data  = ref_mem[a];
        exp_lanes = ddr ? 2'b11 : (lane ? 2'b10 : 2'b01);
        exp_req   = req;
        pend_w    = v && w;
        pend_a    = a;
        pend_m    = ddr ? 2'b11 : (lane ? 2'b10 : 2'b01);
        pend_d    = d;
    endtask

    task automatic idle();
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0, "");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0; cmd_write = 1'b0; wr_data = '0;
        pend_w = 1'b0; exp_vld = 1'b0;
        for (int i = 0; i < 256; i++) ref_mem[i] = init_word(i[7:0]);
        repeat (2) @(negedge clk);
        chk("R1 rd_valid in reset", {31'd0, rd_valid}, 32'd0);
        rst_n = 1'b1;
    endtask

    // Vector: {valid, write, ddr, lane, addr[7:0], data[31:0]}
    localparam int NV = 14;
    localparam logic [43:0] VEC [NV] = '{
        {4'b1110, 8'h10, 32'h1111_2222},  // R2 write pair
        {4'b1010, 8'h10, 32'h0},          // R6 read while its data arrives
        {4'b1110, 8'h10, 32'h3333_4444},
        {4'b1110, 8'h20, 32'h5555_6666},
        {4'b1010, 8'h10, 32'h0},          // R7 younger stage wins
        {4'b1101, 8'h30, 32'hAAAA_BBBB},  // R8 single lane 1
        {4'b1010, 8'h30, 32'h0},          // R8 merge with array lane 0
        {4'b0000, 8'h00, 32'h0},
        {4'b1000, 8'h30, 32'h0},          // R9 single-rate read lane 0
        {4'b1100, 8'h30, 32'h1234_5678},  // R8 single lane 0
        {4'b0000, 8'h00, 32'h0},
        {4'b1010, 8'h30, 32'h0},          // R7 lanes from two stages
        {4'b1010, 8'h40, 32'h0},          // R3 plain array read
        {4'b1001, 8'h20, 32'h0}           // R9 single-rate read lane 1
    };

    int base;

    initial begin
        do_reset();
        @(negedge clk);
        chk("R1 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
        chk("R1 arr_wr_en after reset", {31'd0, arr_wr_en}, 32'd0);
        chk("R1 arr_rd_en after reset", {31'd0, arr_rd_en}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            cycle(VEC[i][43], VEC[i][42], VEC[i][41], VEC[i][40], VEC[i][39:32],
                  VEC[i][31:0], "R6/R7/R8 vector");
        end
        idle(); idle();

        // R4 / R10: third write pushes the first into the array
        do_reset();
        #1 base = n_commit;
        cycle(1'b1, 1'b1, 1'b0, 1'b1, 8'h60, 32'hDEAD_BEEF, "R4");
        cycle(1'b1, 1'b1, 1'b1, 1'b0, 8'h61, 32'h0101_0202, "R4");
        cycle(1'b1, 1'b1, 1'b1, 1'b0, 8'h62, 32'h0303_0404, "R4");
        idle(); idle();
        #1;
        chk("R4 one commit after third data", n_commit - base, 1);
        chk("R4 committed address", {24'd0, last_addr}, 32'h60);
        chk("R10 commit mask lane 1", {30'd0, last_mask}, 32'd2);
        chk("R10 commit data lane 1", {16'd0, last_data[31:16]}, 32'h0000_DEAD);

        // R5: reads only, nothing moves; queued entries still forwarded
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 8'h60, 32'h0, "R5 read committed");
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 8'h61, 32'h0, "R5 read queued");
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 8'h62, 32'h0, "R5 read queued");
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 8'h61, 32'h0, "R5 read queued");
        cycle(1'b1, 1'b0, 1'b0, 1'b1, 8'h62, 32'h0, "R5 read queued");
        idle(); idle(); idle();
        #1 chk("R5 no commit during reads", n_commit - base, 1);

        cycle(1'b1, 1'b1, 1'b1, 1'b0, 8'h63, 32'h0505_0606, "R4");
        idle(); idle();
        #1;
        chk("R4 second commit count", n_commit - base, 2);
        chk("R4 second commit address", {24'd0, last_addr}, 32'h61);
        chk("R10 full-pair mask", {30'd0, last_mask}, 32'd3);

        // R1: reset drops queued writes
        cycle(1'b1, 1'b1, 1'b1, 1'b0, 8'h50, 32'h7777_8888, "R1");
        cycle(1'b1, 1'b1, 1'b1, 1'b0, 8'h51, 32'h9999_AAAA, "R1");
        idle();
        do_reset();
        #1 base = n_commit;
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 8'h50, 32'h0, "R1 dropped entry");
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 8'h51, 32'h0, "R1 dropped entry");
        idle(); idle();
        #1 chk("R1 no commit of dropped entries", n_commit - base, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
            $finish;
        end
    end

endmodule